// File: doc/BRIEF.md
# Pattern-Driven Row Readout Sequencer

This block drives the per-row control lines of a rolling-shutter pixel matrix from the main readout clock. Each row occupies a slot of 16 clock cycles. Every control line is replayed from a user-supplied 16-bit word, one bit per slot cycle, so the row timing is set entirely by configuration and not by a fixed state machine. The pixel power line takes a 32-bit word that covers two slots in a row.

An asynchronous start token is synchronised and edge-detected. Its rising edge restarts the clock dividers and re-arms the sequencer. Once the token has dropped, the sequencer waits for the next falling edge of the divide-by-16 clock, lets five slots pass, and then starts at row 0. Frames then repeat with no further action. The same start edge restarts this sequence at any point in a frame.

A marker-enable input, sampled at the close of each frame, arms frame markers for the following frame. Two row fields place the analogue and digital test markers. The frame length comes from a last-row field, and two extra rows can be appended at the end of each frame.

Top module: `row_seq`

## Requirements
- R1: While reset is asserted and until readout starts, every strobe, marker, sampling clock and `readActive` is 0 and `rowIdx` is 0. After reset the divider phase counts up from 0: `clkDiv2` is phase bit 0, and `clkDiv16` is high for phases 8 to 15.
- R2: On the third rising clock edge at which `startIn` is high, after a low period of at least three edges, the divider phase returns to 0 and any readout in progress stops.
- R3: Once `startIn` has been seen low, readout begins at the next phase-15 to phase-0 wrap, that is a falling edge of `clkDiv16`, plus 80 further cycles (five slots). At that point `readActive` rises with `rowIdx` 0 at phase 0.
- R4: While `readActive` is 1, each of `rowSelect`, `rowReset`, `rowClamp`, `rowCalib`, `rowRead` and `rowLatch` equals bit k of its own pattern word, where k is the phase (0 to 15) within the row slot.
- R5: While `readActive` is 1, `rowPower` equals bit (16·h + k) of `patPower`. Here h is 0 in the first slot after readout starts and alternates every slot after that.
- R6: `rowIdx` advances by one at every phase-15 edge. At the end of the slot whose row equals the last row it wraps to 0. With line-marker mode off, the last row is `lastRow`.
- R7: With `lineMarkMode` set, the last row is `lastRow` + 2, so two extra rows close each frame.
- R8: A new start token during readout stops the strobes three edges after it is raised. The sequence of R3 then repeats from row 0.
- R9: `anaSampClk` is the OR of `rowRead` and `rowCalib`.
- R10: The value of `markEn` at the last cycle of a frame arms the frame markers for the whole next frame. A start edge disarms them. While `markEn` is low, `anaMark` and `digMark` are 0.
- R11: With `markMode` 0 and markers armed, `anaMark` is high during the whole last-row slot, and `digMark` is high only in phase 15 of that slot.
- R12: With `markMode` 1 and markers armed, `anaMark` follows `anaSampClk` and `digMark` follows `clkDiv2` during readout.
- R13: During readout, `anaTestMk` is high for the whole slot of row `anaMkRow`, and `digTestMk` is high for the whole slot of row `digMkRow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main readout clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Asynchronous start token |
| markEn | input | 1 | Frame marker enable, synchronous |
| markMode | input | 1 | 0: pulse markers, 1: clock-copy markers |
| lineMarkMode | input | 1 | Append two rows per frame |
| patSelect | input | 16 | Row-select pattern |
| patReset | input | 16 | Pixel reset pattern |
| patClamp | input | 16 | Clamp pattern |
| patCalib | input | 16 | Calibrate sample pattern |
| patRead | input | 16 | Read sample pattern |
| patLatch | input | 16 | Discriminator latch pattern |
| patPower | input | 32 | Two-slot pixel power pattern |
| lastRow | input | 10 | Index of last matrix row |
| anaMkRow | input | 10 | Row of analogue test marker |
| digMkRow | input | 10 | Row of digital test marker |
| rowSelect | output | 1 | Row-select strobe |
| rowReset | output | 1 | Pixel reset strobe |
| rowClamp | output | 1 | Clamp strobe |
| rowCalib | output | 1 | Calibrate strobe |
| rowRead | output | 1 | Read strobe |
| rowLatch | output | 1 | Latch strobe |
| rowPower | output | 1 | Pixel power strobe |
| rowIdx | output | 10 | Current row |
| readActive | output | 1 | Readout running |
| clkDiv2 | output | 1 | Main clock divided by 2 |
| clkDiv16 | output | 1 | Main clock divided by 16 |
| anaSampClk | output | 1 | Analogue sampling clock |
| anaMark | output | 1 | Analogue frame marker |
| digMark | output | 1 | Digital frame marker |
| anaTestMk | output | 1 | Analogue test-row marker |
| digTestMk | output | 1 | Digital test-row marker |

## Verification
The row-bound assertion relies on `lastRow` and `lineMarkMode` staying fixed while readout runs. A smaller bound written mid-frame could leave `rowIdx` past it for the rest of that frame. The bench therefore changes frame configuration only while reset is held. `markEn` is taken as a synchronous input and is driven only at falling clock edges. The start token is held high for several cycles and low for much longer than the synchroniser depth, so every pulse yields exactly one start edge.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  localparam int SLOT_CYCLES = 16;                 // power of two
  localparam int PHASE_W     = $clog2(SLOT_CYCLES);
  localparam int ROW_W       = 10;
  localparam int LAT_SLOTS   = 5;
  localparam int EXTRA_ROWS  = 2;
  localparam int NUM_STRB    = 6;
  localparam int PWR_W       = 2 * SLOT_CYCLES;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_LAT, S_RUN} seqState_t;

  typedef struct packed {
    logic               run;
    logic [PHASE_W-1:0] phase;
    logic [ROW_W-1:0]   rowIdx;
    logic               pairHalf;
    logic               lastSlot;
    logic               frameEnd;
    logic               resync;
  } seqBus_t;
endpackage

// File: rtl/row_seq_ctrl.sv
module row_seq_ctrl
  import row_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [ROW_W-1:0] lastRow,
  input  logic             lineMarkMode,
  output seqBus_t          bus
);
  localparam int LAT_W = $clog2(LAT_SLOTS + 1);

  logic tokS1, tokS2, tokD;
  logic tokRise;
  seqState_t state;
  logic [PHASE_W-1:0] phase;
  logic [LAT_W-1:0]   latCnt;
  logic [ROW_W-1:0]   rowIdx;
  logic               pairHalf;
  logic [ROW_W:0]     endRow;
  logic               slotEnd, run, lastSlot;

  // two-flop synchroniser plus edge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokS1 <= 1'b0;
      tokS2 <= 1'b0;
      tokD  <= 1'b0;
    end else begin
      tokS1 <= startIn;
      tokS2 <= tokS1;
      tokD  <= tokS2;
    end
  end
  assign tokRise = tokS2 & ~tokD;

  assign endRow   = {1'b0, lastRow} + (lineMarkMode ? (ROW_W+1)'(EXTRA_ROWS) : '0);
  assign slotEnd  = (phase == PHASE_W'(SLOT_CYCLES - 1));
  assign run      = (state == S_RUN);
  assign lastSlot = run && ({1'b0, rowIdx} >= endRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= '0;
      latCnt   <= '0;
      rowIdx   <= '0;
      pairHalf <= 1'b0;
    end else if (tokRise) begin
      state  <= S_ARMED;
      phase  <= '0;
      latCnt <= '0;
    end else begin
      phase <= phase + 1'b1;
      case (state)
        S_ARMED: if (!tokS2 && slotEnd) begin
          state  <= S_LAT;
          latCnt <= '0;
        end
        S_LAT: if (slotEnd) begin
          if (latCnt == LAT_W'(LAT_SLOTS - 1)) begin
            state    <= S_RUN;
            rowIdx   <= '0;
            pairHalf <= 1'b0;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        S_RUN: if (slotEnd) begin
          pairHalf <= ~pairHalf;
          rowIdx   <= lastSlot ? '0 : rowIdx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign bus.run      = run;
  assign bus.phase    = phase;
  assign bus.rowIdx   = rowIdx;
  assign bus.pairHalf = pairHalf;
  assign bus.lastSlot = lastSlot;
  assign bus.frameEnd = lastSlot && slotEnd;
  assign bus.resync   = tokRise;

  // R6: row index holds inside a slot
  a_r6_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    (run && !slotEnd) |=> (rowIdx == $past(rowIdx)));

  // R6: row wraps to 0 after the last slot of a frame
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (run && lastSlot && slotEnd && !tokRise) |=> (rowIdx == '0));

  // R3: readout always enters at row 0, phase 0
  a_r3_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> (phase == '0 && rowIdx == '0));

  // R7: row index never passes the frame bound while configuration is static
  a_r7_row_bound: assert property (@(posedge clk) disable iff (!rstN)
    run |-> ({1'b0, rowIdx} <= endRow));
endmodule

// File: rtl/row_seq_dpath.sv
module row_seq_dpath
  import row_seq_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  seqBus_t                               bus,
  input  logic [NUM_STRB-1:0][SLOT_CYCLES-1:0]  patBank,
  input  logic [PWR_W-1:0]                      patPower,
  input  logic                                  markEn,
  input  logic                                  markMode,
  input  logic [ROW_W-1:0]                      anaMkRow,
  input  logic [ROW_W-1:0]                      digMkRow,
  output logic [NUM_STRB-1:0]                   strb,
  output logic                                  rowPower,
  output logic                                  clkDiv2,
  output logic                                  clkDiv16,
  output logic                                  anaSampClk,
  output logic                                  anaMark,
  output logic                                  digMark,
  output logic                                  anaTestMk,
  output logic                                  digTestMk
);
  localparam int IDX_READ  = 4;
  localparam int IDX_CALIB = 3;

  logic markLive;
  logic markOn;

  for (genvar g = 0; g < NUM_STRB; g++) begin : gStrb
    assign strb[g] = bus.run & patBank[g][bus.phase];
  end

  assign rowPower   = bus.run & patPower[{bus.pairHalf, bus.phase}];
  assign clkDiv2    = bus.phase[0];
  assign clkDiv16   = bus.phase[PHASE_W-1];
  assign anaSampClk = strb[IDX_READ] | strb[IDX_CALIB];

  // marker arming: sampled at frame close, dropped on resync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             markLive <= 1'b0;
    else if (bus.resync)   markLive <= 1'b0;
    else if (bus.frameEnd) markLive <= markEn;
  end

  assign markOn  = markLive & markEn & bus.run;
  assign anaMark = markOn & (markMode ? anaSampClk : bus.lastSlot);
  assign digMark = markOn & (markMode ? clkDiv2
                                      : (bus.lastSlot && bus.phase == PHASE_W'(SLOT_CYCLES - 1)));

  assign anaTestMk = bus.run && (bus.rowIdx == anaMkRow);
  assign digTestMk = bus.run && (bus.rowIdx == digMkRow);

  // R11: in pulse mode the digital marker lies inside the analogue window
  a_r11_dig_in_ana: assert property (@(posedge clk) disable iff (!rstN)
    (!markMode && digMark) |-> anaMark);

  // R10: no frame marker outside readout
  a_r10_mark_idle: assert property (@(posedge clk) disable iff (!rstN)
    !bus.run |-> (!anaMark && !digMark));

  // R5: power pattern half flips on each slot boundary during readout
  a_r5_half_flip: assert property (@(posedge clk) disable iff (!rstN)
    (bus.run && bus.phase == PHASE_W'(SLOT_CYCLES - 1) && !bus.resync)
      |=> (bus.pairHalf != $past(bus.pairHalf)));
endmodule

// File: rtl/row_seq.sv
module row_seq
  import row_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic                   markEn,
  input  logic                   markMode,
  input  logic                   lineMarkMode,
  input  logic [SLOT_CYCLES-1:0] patSelect,
  input  logic [SLOT_CYCLES-1:0] patReset,
  input  logic [SLOT_CYCLES-1:0] patClamp,
  input  logic [SLOT_CYCLES-1:0] patCalib,
  input  logic [SLOT_CYCLES-1:0] patRead,
  input  logic [SLOT_CYCLES-1:0] patLatch,
  input  logic [PWR_W-1:0]       patPower,
  input  logic [ROW_W-1:0]       lastRow,
  input  logic [ROW_W-1:0]       anaMkRow,
  input  logic [ROW_W-1:0]       digMkRow,
  output logic                   rowSelect,
  output logic                   rowReset,
  output logic                   rowClamp,
  output logic                   rowCalib,
  output logic                   rowRead,
  output logic                   rowLatch,
  output logic                   rowPower,
  output logic [ROW_W-1:0]       rowIdx,
  output logic                   readActive,
  output logic                   clkDiv2,
  output logic                   clkDiv16,
  output logic                   anaSampClk,
  output logic                   anaMark,
  output logic                   digMark,
  output logic                   anaTestMk,
  output logic                   digTestMk
);
  seqBus_t bus;
  logic [NUM_STRB-1:0][SLOT_CYCLES-1:0] patBank;
  logic [NUM_STRB-1:0] strb;

  assign patBank = {patLatch, patRead, patCalib, patClamp, patReset, patSelect};

  row_seq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .startIn      (startIn),
    .lastRow      (lastRow),
    .lineMarkMode (lineMarkMode),
    .bus          (bus)
  );

  row_seq_dpath uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .bus        (bus),
    .patBank    (patBank),
    .patPower   (patPower),
    .markEn     (markEn),
    .markMode   (markMode),
    .anaMkRow   (anaMkRow),
    .digMkRow   (digMkRow),
    .strb       (strb),
    .rowPower   (rowPower),
    .clkDiv2    (clkDiv2),
    .clkDiv16   (clkDiv16),
    .anaSampClk (anaSampClk),
    .anaMark    (anaMark),
    .digMark    (digMark),
    .anaTestMk  (anaTestMk),
    .digTestMk  (digTestMk)
  );

  assign rowSelect  = strb[0];
  assign rowReset   = strb[1];
  assign rowClamp   = strb[2];
  assign rowCalib   = strb[3];
  assign rowRead    = strb[4];
  assign rowLatch   = strb[5];
  assign rowIdx     = bus.rowIdx;
  assign readActive = bus.run;
endmodule

// File: tb/row_seq_test.sv
module row_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, markEn = 1'b0, markMode = 1'b0, lineMarkMode = 1'b0;
  logic [15:0] patSelect = '0, patReset = '0, patClamp = '0, patCalib = '0, patRead = '0, patLatch = '0;
  logic [31:0] patPower = '0;
  logic [9:0]  lastRow = '0, anaMkRow = '0, digMkRow = '0;
  logic rowSelect, rowReset, rowClamp, rowCalib, rowRead, rowLatch, rowPower;
  logic [9:0] rowIdx;
  logic readActive, clkDiv2, clkDiv16, anaSampClk, anaMark, digMark, anaTestMk, digTestMk;

  int vectors = 0;
  int miscompares = 0;
  bit resyncSeen = 0;

  always #4 clk = ~clk;

  row_seq uut (.*);

  // behavioural reference: counters and a state number
  int  mPh = 0, mSt = 0, mWait = 0, mRow = 0;
  bit  mHalf = 0, mLive = 0;
  bit  h1 = 0, h2 = 0, h3 = 0;

  function automatic int frameLast();
    return int'(lastRow) + (lineMarkMode ? 2 : 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mSt = 0; mWait = 0; mRow = 0; mHalf = 0; mLive = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit rise, closing;
      rise    = h2 && !h3;
      closing = (mSt == 3) && (mPh == 15) && (mRow >= frameLast());
      if (rise) begin
        mPh = 0; mSt = 1; mLive = 0;
      end else begin
        if (closing) mLive = markEn;
        if (mSt == 1 && !h2 && mPh == 15) begin
          mSt = 2; mWait = 80;
        end else if (mSt == 2) begin
          mWait--;
          if (mWait == 0) begin mSt = 3; mRow = 0; mHalf = 0; end
        end else if (mSt == 3 && mPh == 15) begin
          mHalf = !mHalf;
          mRow  = closing ? 0 : mRow + 1;
        end
        mPh = (mPh + 1) % 16;
      end
      h3 = h2; h2 = h1; h1 = startIn;
    end
  end

  task automatic chk(string req, string name, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit run, eRead, eCalib, eSamp, lastS, on, eAna, eDig;
    string mk;
    run    = (mSt == 3);
    eRead  = run && patRead[mPh];
    eCalib = run && patCalib[mPh];
    eSamp  = eRead || eCalib;
    lastS  = run && (mRow >= frameLast());
    on     = mLive && markEn && run;
    eAna   = on && (markMode ? eSamp : lastS);
    eDig   = on && (markMode ? (mPh % 2 == 1) : (lastS && mPh == 15));
    chk("R2", "clkDiv2", 32'(clkDiv2), 32'(mPh % 2));
    chk("R2", "clkDiv16", 32'(clkDiv16), 32'(mPh >= 8));
    chk(resyncSeen ? "R8" : "R3", "readActive", 32'(readActive), 32'(run));
    chk("R4", "rowSelect", 32'(rowSelect), 32'(run && patSelect[mPh]));
    chk("R4", "rowReset", 32'(rowReset), 32'(run && patReset[mPh]));
    chk("R4", "rowClamp", 32'(rowClamp), 32'(run && patClamp[mPh]));
    chk("R4", "rowCalib", 32'(rowCalib), 32'(eCalib));
    chk("R4", "rowRead", 32'(rowRead), 32'(eRead));
    chk("R4", "rowLatch", 32'(rowLatch), 32'(run && patLatch[mPh]));
    chk("R5", "rowPower", 32'(rowPower), 32'(run && patPower[mHalf * 16 + mPh]));
    chk(lineMarkMode ? "R7" : "R6", "rowIdx", 32'(rowIdx), 32'(mRow));
    chk("R9", "anaSampClk", 32'(anaSampClk), 32'(eSamp));
    mk = !markEn ? "R10" : (markMode ? "R12" : "R11");
    chk(mk, "anaMark", 32'(anaMark), 32'(eAna));
    chk(mk, "digMark", 32'(digMark), 32'(eDig));
    chk("R13", "anaTestMk", 32'(anaTestMk), 32'(run && mRow == int'(anaMkRow)));
    chk("R13", "digTestMk", 32'(digTestMk), 32'(run && mRow == int'(digMkRow)));
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic pulseStart(int hi);
    startIn = 1'b1;
    step(hi);
    startIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    step(3);
    // R1: quiet outputs under reset
    chk("R1", "resetOutputs",
        32'({rowSelect, rowReset, rowClamp, rowCalib, rowRead, rowLatch, rowPower,
             readActive, anaSampClk, anaMark, digMark, anaTestMk, digTestMk, clkDiv16}), 32'h0);
    chk("R1", "resetRowIdx", 32'(rowIdx), 32'h0);
    rstN = 1'b1;
    patSelect = 16'h7FFF; patReset = 16'h0040; patClamp = 16'h01C0;
    patCalib  = 16'h3C00; patRead  = 16'h001C; patLatch = 16'h6000;
    patPower  = 32'h7FFF_FFFF;
    lastRow = 10'd5; anaMkRow = 10'd2; digMkRow = 10'd4;
    step(5);
    pulseStart(6);
    step(250);
    markEn = 1'b1; markMode = 1'b0;
    step(300);
    markEn = 1'b0;
    step(60);
    markEn = 1'b1; markMode = 1'b1;
    step(250);
    // R8: resync in the middle of a frame
    pulseStart(4);
    resyncSeen = 1'b1;
    step(260);
    // second configuration with line-marker rows (R7)
    rstN = 1'b0;
    step(2);
    resyncSeen = 1'b0;
    lineMarkMode = 1'b1; lastRow = 10'd3; anaMkRow = 10'd5; digMkRow = 10'd0;
    patSelect = 16'hA5C3; patReset = 16'h8001; patClamp = 16'h0FF0;
    patCalib  = 16'h1248; patRead  = 16'h0300; patLatch = 16'hC00C;
    patPower  = 32'h0F0F_A5A5;
    markEn = 1'b1; markMode = 1'b0;
    rstN = 1'b1;
    step(7);
    pulseStart(5);
    step(330);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end
endmodule